// File: doc/BRIEF.md
# Way Lookup Hit-Info Queue

This block is a first-in first-out buffer placed between the tag lookup stage and the data read stage of an instruction cache with 4 ways and 64-byte lines. For each fetch or prefetch request, the lookup stage pushes one entry. An entry carries the set index, the physical tag returned by address translation, a 4-bit per-way hit vector and a 2-bit translation fault code. The data read stage pops entries in the same order they were pushed.

While entries wait in the queue, the miss handling logic may write a line into the cache. That write is presented on the refill port. Every waiting entry whose set and tag match the write has its hit vector rewritten to point at the written way, so the read stage never acts on stale hit information. The queue has a fixed depth. Once it is full it stops accepting new entries, and this is what limits how far the prefetch side can run ahead of the read side. A flush empties the queue in one cycle. When the queue is empty and the consumer is ready, an incoming entry passes straight through to the output in the same cycle.

Top module: `way_lookup_queue`

## Requirements
- R1: Entries appear on the output in the order they were accepted, and each entry appears exactly once.
- R2: The set index, tag, hit vector and fault code of an entry reach the output unchanged, unless a refill matches the entry (R4, R5, R6). A hit vector of all zeros means a miss and is carried through as all zeros.
- R3: `enq_ready_o` is low exactly when DEPTH entries are held. Readiness depends only on occupancy. An enqueue offered while `enq_ready_o` is low is dropped and never appears on the output.
- R4: A refill with `refill_valid_i` high rewrites the hit vector of every queued entry whose set and tag both equal the refill's. The new vector has only bit `refill_way_i` set (bit 0 = way 0). Entries that differ in set or tag are left unchanged, and the fault code is never changed.
- R5: A refill in the same cycle as an accepted enqueue is also applied to the entry being enqueued.
- R6: The output fields reflect a matching refill presented in the same cycle. This includes the cycle in which the entry leaves the queue.
- R7: While `flush_i` is high, `deq_valid_o` is low and any offered enqueue is dropped. In the next cycle the queue is empty.
- R8: When the queue is empty, an offered enqueue shows on the output in the same cycle. If `deq_ready_i` is also high, the entry is consumed and is not stored.
- R9: While `deq_valid_o` is high and `deq_ready_i` is low, the same head entry stays on the output.
- R10: During and after reset the queue is empty: `deq_valid_o` is low and `enq_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties the queue |
| enq_valid_i | input | 1 | Producer offers an entry |
| enq_ready_o | output | 1 | Queue can accept an entry (backpressure) |
| enq_set_i | input | SET_W (7) | Set index of the request |
| enq_tag_i | input | TAG_W (23) | Physical tag from translation |
| enq_hit_i | input | WAYS (4) | Per-way hit vector, all zero = miss |
| enq_fault_i | input | FAULT_W (2) | Translation fault code |
| deq_valid_o | output | 1 | Output entry is valid |
| deq_ready_i | input | 1 | Consumer takes the output entry |
| deq_set_o | output | SET_W (7) | Set index of the head entry |
| deq_tag_o | output | TAG_W (23) | Tag of the head entry |
| deq_hit_o | output | WAYS (4) | Hit vector of the head entry, refill applied |
| deq_fault_o | output | FAULT_W (2) | Fault code of the head entry |
| refill_valid_i | input | 1 | A line is being written into the cache |
| refill_set_i | input | SET_W (7) | Set of the written line |
| refill_tag_i | input | TAG_W (23) | Tag of the written line |
| refill_way_i | input | WAY_W (2) | Way of the written line |

## Verification
The hardest situations to reach are those where a refill coincides with some other event. One is a refill that lands on an entry in the very cycle that entry is accepted or leaves. Another is a refill that matches several queued entries while neighbours sharing only the set or only the tag must stay untouched. The stimulus holds `deq_ready_i` low to build up a mixed queue before firing a refill. Directed cycles assert the refill together with an enqueue, together with the dequeuing handshake, and together with the empty-queue pass-through. A random phase then keeps sets and tags within a range of four values each, so matches, flushes and full-queue stalls occur often. The scoreboard model applies every refill to its expected entries and compares on every cycle the output is valid.

// File: rtl/wlq_pkg.sv
package wlq_pkg;
  parameter int unsigned WAYS       = 4;
  parameter int unsigned LINE_BYTES = 64;
  parameter int unsigned SETS       = 128;
  parameter int unsigned PADDR_W    = 36;
  parameter int unsigned FAULT_W    = 2;

  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned OFS_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = PADDR_W - SET_W - OFS_W;
  localparam int unsigned WAY_W = $clog2(WAYS);

  typedef struct packed {
    logic [SET_W-1:0]   set_idx;
    logic [TAG_W-1:0]   ptag;
    logic [WAYS-1:0]    hit;
    logic [FAULT_W-1:0] fault;
  } wlq_entry_t;

  typedef struct packed {
    logic             vld;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] ptag;
    logic [WAY_W-1:0] way;
  } wlq_refill_t;
endpackage

// File: rtl/wlq_fix.sv
// Applies a refill write to one entry: on set+tag match the hit vector becomes one-hot.
module wlq_fix
  import wlq_pkg::*;
(
  input  wlq_entry_t  ent_i,
  input  wlq_refill_t rf_i,
  output wlq_entry_t  ent_o
);
  logic match;

  assign match = rf_i.vld && (ent_i.set_idx == rf_i.set_idx) && (ent_i.ptag == rf_i.ptag);

  always_comb begin
    ent_o = ent_i;
    if (match) begin
      ent_o.hit             = '0;
      ent_o.hit[rf_i.way]   = 1'b1;
    end
  end
endmodule

// File: rtl/wlq_ctrl.sv
module wlq_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      occ_q <= occ_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign occ_o   = occ_q;
  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == CNT_W'(DEPTH));
endmodule

// File: rtl/wlq_store.sv
// Entry array; every slot re-applies the refill each cycle, read port returns the patched value.
module wlq_store
  import wlq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  wlq_entry_t       wdata_i,
  input  wlq_refill_t      rf_i,
  input  logic [PTR_W-1:0] raddr_i,
  output wlq_entry_t       rdata_o
);
  wlq_entry_t ent_q [DEPTH];
  wlq_entry_t fixed [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    wlq_fix u_fix (
      .ent_i (ent_q[i]),
      .rf_i  (rf_i),
      .ent_o (fixed[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[i] <= '0;
      else if (we_i && waddr_i == PTR_W'(i))    ent_q[i] <= wdata_i;
      else                                      ent_q[i] <= fixed[i];
    end
  end

  assign rdata_o = fixed[raddr_i];
endmodule

// File: rtl/way_lookup_queue.sv
module way_lookup_queue
  import wlq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               enq_valid_i,
  output logic               enq_ready_o,
  input  logic [SET_W-1:0]   enq_set_i,
  input  logic [TAG_W-1:0]   enq_tag_i,
  input  logic [WAYS-1:0]    enq_hit_i,
  input  logic [FAULT_W-1:0] enq_fault_i,
  output logic               deq_valid_o,
  input  logic               deq_ready_i,
  output logic [SET_W-1:0]   deq_set_o,
  output logic [TAG_W-1:0]   deq_tag_o,
  output logic [WAYS-1:0]    deq_hit_o,
  output logic [FAULT_W-1:0] deq_fault_o,
  input  logic               refill_valid_i,
  input  logic [SET_W-1:0]   refill_set_i,
  input  logic [TAG_W-1:0]   refill_tag_i,
  input  logic [WAY_W-1:0]   refill_way_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  wlq_refill_t      rf;
  wlq_entry_t       enq_ent, enq_fix, head_fix, out_ent;
  logic             empty, full, push, pop, bypass;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] occ;

  assign rf      = '{vld: refill_valid_i, set_idx: refill_set_i, ptag: refill_tag_i, way: refill_way_i};
  assign enq_ent = '{set_idx: enq_set_i, ptag: enq_tag_i, hit: enq_hit_i, fault: enq_fault_i};

  wlq_fix u_enq_fix (
    .ent_i (enq_ent),
    .rf_i  (rf),
    .ent_o (enq_fix)
  );

  // ready is a function of occupancy only: keeps deq_ready_i off the enq_ready_o path
  assign enq_ready_o = !full;
  assign bypass      = empty && enq_valid_i && deq_ready_i && !flush_i;
  assign push        = enq_valid_i && !full && !flush_i && !bypass;
  assign pop         = !empty && deq_ready_i && !flush_i;
  assign deq_valid_o = !flush_i && (!empty || enq_valid_i);

  wlq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push),
    .pop_i   (pop),
    .wptr_o  (wptr),
    .rptr_o  (rptr),
    .occ_o   (occ),
    .empty_o (empty),
    .full_o  (full)
  );

  wlq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .waddr_i (wptr),
    .wdata_i (enq_fix),
    .rf_i    (rf),
    .raddr_i (rptr),
    .rdata_o (head_fix)
  );

  assign out_ent     = empty ? enq_fix : head_fix;
  assign deq_set_o   = out_ent.set_idx;
  assign deq_tag_o   = out_ent.ptag;
  assign deq_hit_o   = out_ent.hit;
  assign deq_fault_o = out_ent.fault;
endmodule

// File: rtl/wlq_chk.sv
module wlq_chk
  import wlq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               enq_valid_i,
  input logic               enq_ready_o,
  input logic [SET_W-1:0]   enq_set_i,
  input logic [TAG_W-1:0]   enq_tag_i,
  input logic               deq_valid_o,
  input logic               deq_ready_i,
  input logic [SET_W-1:0]   deq_set_o,
  input logic [TAG_W-1:0]   deq_tag_o,
  input logic [WAYS-1:0]    deq_hit_o,
  input logic               refill_valid_i,
  input logic [SET_W-1:0]   refill_set_i,
  input logic [TAG_W-1:0]   refill_tag_i,
  input logic [WAY_W-1:0]   refill_way_i,
  input logic [CNT_W-1:0]   occ,
  input logic               empty
);
  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(DEPTH));

  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == CNT_W'(DEPTH)) |-> !enq_ready_o);

  p_flush_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (occ == '0));

  p_flush_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !deq_valid_o);

  p_refill_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && refill_valid_i && deq_set_o == refill_set_i && deq_tag_o == refill_tag_i)
      |-> (deq_hit_o == (WAYS'(1) << refill_way_i)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i && !flush_i)
      |=> (flush_i || (deq_valid_o && $stable(deq_tag_o) && $stable(deq_set_o))));

  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && enq_valid_i && !flush_i)
      |-> (deq_valid_o && deq_tag_o == enq_tag_i && deq_set_o == enq_set_i));

  p_bypass_nostore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && enq_valid_i && deq_ready_i && !flush_i) |=> (occ == '0));

  p_empty_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && !enq_valid_i) |-> !deq_valid_o);
endmodule

bind way_lookup_queue wlq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .enq_valid_i    (enq_valid_i),
  .enq_ready_o    (enq_ready_o),
  .enq_set_i      (enq_set_i),
  .enq_tag_i      (enq_tag_i),
  .deq_valid_o    (deq_valid_o),
  .deq_ready_i    (deq_ready_i),
  .deq_set_o      (deq_set_o),
  .deq_tag_o      (deq_tag_o),
  .deq_hit_o      (deq_hit_o),
  .refill_valid_i (refill_valid_i),
  .refill_set_i   (refill_set_i),
  .refill_tag_i   (refill_tag_i),
  .refill_way_i   (refill_way_i),
  .occ            (occ),
  .empty          (empty)
);

// File: tb/sim_way_lookup_queue.sv
`timescale 1ns/1ps
module sim_way_lookup_queue;
  import wlq_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic enq_valid_i = 1'b0, enq_ready_o, deq_valid_o, deq_ready_i = 1'b0;
  logic [SET_W-1:0]   enq_set_i = '0, deq_set_o, refill_set_i = '0;
  logic [TAG_W-1:0]   enq_tag_i = '0, deq_tag_o, refill_tag_i = '0;
  logic [WAYS-1:0]    enq_hit_i = '0, deq_hit_o;
  logic [FAULT_W-1:0] enq_fault_i = '0, deq_fault_o;
  logic               refill_valid_i = 1'b0;
  logic [WAY_W-1:0]   refill_way_i = '0;

  way_lookup_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o),
    .enq_set_i(enq_set_i), .enq_tag_i(enq_tag_i), .enq_hit_i(enq_hit_i), .enq_fault_i(enq_fault_i),
    .deq_valid_o(deq_valid_o), .deq_ready_i(deq_ready_i),
    .deq_set_o(deq_set_o), .deq_tag_o(deq_tag_o), .deq_hit_o(deq_hit_o), .deq_fault_o(deq_fault_o),
    .refill_valid_i(refill_valid_i), .refill_set_i(refill_set_i),
    .refill_tag_i(refill_tag_i), .refill_way_i(refill_way_i)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit done = 1'b0;
  wlq_entry_t mq[$];
  wlq_entry_t cur, exp_e;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // scoreboard monitor: mid-cycle, inputs and outputs settled
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(enq_ready_o == (mq.size() < DEPTH), "R3", "enq_ready_o",
          64'(enq_ready_o), 64'(mq.size() < DEPTH));
      if (flush_i) begin
        chk(!deq_valid_o, "R7", "deq_valid_o in flush", 64'(deq_valid_o), 64'd0);
        mq.delete();
      end else begin
        if (enq_valid_i && enq_ready_o)
          mq.push_back('{set_idx: enq_set_i, ptag: enq_tag_i, hit: enq_hit_i, fault: enq_fault_i});
        if (refill_valid_i)
          foreach (mq[k])
            if (mq[k].set_idx == refill_set_i && mq[k].ptag == refill_tag_i)
              mq[k].hit = WAYS'(1) << refill_way_i;
        chk(deq_valid_o == (mq.size() > 0), phase, "deq_valid_o",
            64'(deq_valid_o), 64'(mq.size() > 0));
        if (deq_valid_o && mq.size() > 0) begin
          cur   = '{set_idx: deq_set_o, ptag: deq_tag_o, hit: deq_hit_o, fault: deq_fault_o};
          exp_e = mq[0];
          chk(cur == exp_e, phase, "deq entry", 64'(cur), 64'(exp_e));
          if (deq_ready_i) void'(mq.pop_front());
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input int s, input int t, input int h, input int f);
    bit acc;
    enq_valid_i = 1'b1;
    enq_set_i   = SET_W'(s);
    enq_tag_i   = TAG_W'(t);
    enq_hit_i   = WAYS'(h);
    enq_fault_i = FAULT_W'(f);
    do begin
      @(negedge clk);
      acc = enq_ready_o && !flush_i;
      tick();
    end while (!acc);
    enq_valid_i = 1'b0;
  endtask

  task automatic drain();
    deq_ready_i = 1'b1;
    for (int k = 0; k < 4 * DEPTH && mq.size() != 0; k++) tick();
    deq_ready_i = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    chk(!deq_valid_o, "R10", "deq_valid_o in reset", 64'(deq_valid_o), 64'd0);
    chk(enq_ready_o, "R10", "enq_ready_o in reset", 64'(enq_ready_o), 64'd1);
    tick();
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!deq_valid_o, "R10", "deq_valid_o after reset", 64'(deq_valid_o), 64'd0);
    tick();

    // R1: ordering with build-up then drain while pushing
    phase = "R1";
    for (int i = 0; i < 5; i++) push(i, 'h100 + i, 1 << (i % 4), i % 4);
    deq_ready_i = 1'b1;
    for (int i = 0; i < 4; i++) push(10 + i, 'h200 + i, 0, 1);
    drain();

    // R3: fill, then offer while full
    phase = "R3";
    for (int i = 0; i < DEPTH; i++) push(20 + i, 'h300 + i, 2, 0);
    @(negedge clk);
    chk(!enq_ready_o, "R3", "enq_ready_o when full", 64'(enq_ready_o), 64'd0);
    tick();
    enq_valid_i = 1'b1; enq_set_i = 7'h7f; enq_tag_i = 'h7ffff; enq_hit_i = 4'hf; enq_fault_i = 2'd3;
    repeat (3) tick();
    enq_valid_i = 1'b0;
    drain();

    // R4: refill rewrites only matching set+tag entries
    phase = "R4";
    push(5, 'h0aa, 4'b0000, 0);
    push(5, 'h0bb, 4'b0000, 1);
    push(6, 'h0aa, 4'b0010, 2);
    push(5, 'h0aa, 4'b1000, 3);
    refill_valid_i = 1'b1; refill_set_i = 7'd5; refill_tag_i = 'h0aa; refill_way_i = 2'd2;
    tick();
    refill_valid_i = 1'b0;
    drain();

    // R5: refill in the same cycle as enqueue
    phase = "R5";
    push(8, 'h055, 4'b0001, 0);
    enq_valid_i = 1'b1; enq_set_i = 7'd9; enq_tag_i = 'h123; enq_hit_i = 4'b0000; enq_fault_i = 2'd0;
    refill_valid_i = 1'b1; refill_set_i = 7'd9; refill_tag_i = 'h123; refill_way_i = 2'd1;
    tick();
    enq_valid_i = 1'b0; refill_valid_i = 1'b0;
    drain();

    // R6: refill in the same cycle as the dequeue handshake
    phase = "R6";
    push(3, 'h077, 4'b0001, 0);
    push(4, 'h078, 4'b0000, 1);
    deq_ready_i = 1'b1;
    refill_valid_i = 1'b1; refill_set_i = 7'd3; refill_tag_i = 'h077; refill_way_i = 2'd3;
    tick();
    refill_valid_i = 1'b1; refill_set_i = 7'd4; refill_tag_i = 'h078; refill_way_i = 2'd0;
    tick();
    refill_valid_i = 1'b0;
    drain();

    // R7: flush with a concurrent enqueue
    phase = "R7";
    for (int i = 0; i < 3; i++) push(30 + i, 'h400 + i, 1, 0);
    flush_i = 1'b1;
    enq_valid_i = 1'b1; enq_set_i = 7'd40; enq_tag_i = 'h444; enq_hit_i = 4'b0100;
    tick();
    flush_i = 1'b0; enq_valid_i = 1'b0;
    @(negedge clk);
    chk(!deq_valid_o, "R7", "deq_valid_o after flush", 64'(deq_valid_o), 64'd0);
    chk(enq_ready_o, "R7", "enq_ready_o after flush", 64'(enq_ready_o), 64'd1);
    tick();
    push(41, 'h455, 4'b0010, 2);
    drain();

    // R8: pass-through on empty queue
    phase = "R8";
    deq_ready_i = 1'b1;
    push(50, 'h500, 4'b0100, 1);
    @(negedge clk);
    chk(!deq_valid_o, "R8", "bypassed entry not stored", 64'(deq_valid_o), 64'd0);
    tick();
    deq_ready_i = 1'b0;
    push(51, 'h501, 4'b0000, 2);
    drain();

    // R9: hold head while stalled
    phase = "R9";
    push(60, 'h600, 4'b0001, 0);
    push(61, 'h601, 4'b0010, 1);
    repeat (4) tick();
    drain();

    // R2: random traffic with narrow set/tag ranges
    phase = "R2";
    for (int c = 0; c < 600; c++) begin
      enq_valid_i    = ($urandom % 3) != 0;
      enq_set_i      = SET_W'($urandom % 4);
      enq_tag_i      = TAG_W'($urandom % 4);
      enq_hit_i      = (($urandom % 2) != 0) ? '0 : WAYS'(1) << ($urandom % 4);
      enq_fault_i    = FAULT_W'($urandom);
      deq_ready_i    = ($urandom % 3) == 0;
      refill_valid_i = ($urandom % 4) == 0;
      refill_set_i   = SET_W'($urandom % 4);
      refill_tag_i   = TAG_W'($urandom % 4);
      refill_way_i   = WAY_W'($urandom);
      flush_i        = ($urandom % 60) == 0;
      tick();
    end
    enq_valid_i = 1'b0; refill_valid_i = 1'b0; flush_i = 1'b0;
    drain();

    finish_run();
  end
endmodule